// File: doc/BRIEF.md
# Write-Only Two-Wire Control Register Slave

This block is a slave on a two-wire serial bus (I2C-compatible) that only accepts writes. It decodes a seven-bit device address, acknowledges the master, and uses the one data byte that follows to load one of five small control registers. The registers are a mode word, a diagnostic control word, a fault mask and two volume codes. Each register is presented on its own output port to the logic it controls.

The bus lines are brought into the system clock through two-flop synchronisers. Clock edges and the START and STOP conditions are detected from the synchronised lines. SDA is driven only as an open-drain pull-down: the output `sda_oe` asserted means the pad pulls the line low. The upper three bits of the data byte select the target register and the lower five bits carry the value. There is no separate sub-address byte.

Top module: `i2c_wr_regs`

## Requirements
- R1: While reset is asserted, and on the cycle after it, all five register outputs are zero and `sda_oe` is 0.
- R2: The device address is the seven bits 1,1,1,1,1,0,`addr_sel`. It is received MSB first, with each bit sampled on an SCL rising edge, followed by an R/W bit. A match with R/W = 0 is acknowledged: `sda_oe` is 1 from the SCL falling edge after the R/W bit until the next falling edge. `sda_oe` changes only while SCL is low.
- R3: An address that does not match, or a match with R/W = 1, gets no acknowledge. The rest of that transfer writes no register.
- R4: Data bits [7:5] select the register: 000 is mode, 001 is diagnostic control, 010 is fault mask, 011 is volume 1, 100 is volume 2. Bits [4:0] are loaded as the new value once the eighth data bit has been sampled.
- R5: After a matching address, the data byte is acknowledged in the ninth clock, in the same way as the address byte.
- R6: Mode bits [1:0] and diagnostic control bit [0] are reserved and always read zero, whatever value is written.
- R7: A data byte with index 101, 110 or 111 is acknowledged but changes no register.
- R8: A STOP in the middle of a byte ends the transfer without a write. A START in the middle of a byte drops the partial byte without a write and begins a new address phase.
- R9: Bytes after the first data byte of a transfer are not acknowledged and write nothing.
- R10: A single write changes at most one register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_sel | input | 1 | Lowest bit of the device address |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls the data line low (acknowledge) |
| mode_q | output | 5 | Mode register (bit 4 power-on, bit 3 input 2, bit 2 input 1) |
| diag_q | output | 5 | Diagnostic control (bit 4 enable, bit 3 continuous, bit 2 fault reset, bit 1 limit mode) |
| fmask_q | output | 5 | Fault mask register |
| vol1_q | output | 5 | Volume code for input 1 |
| vol2_q | output | 5 | Volume code for input 2 |

## Verification
Two functions can fall in the same stretch of bus activity: the register commit on the eighth data bit, and the acknowledge drive that follows at the next SCL fall. A START or STOP that lands in the middle of a byte also races against a commit. The bench provokes both cases by ending a data byte after four bits with a STOP, and by cutting another with a repeated START. It then judges the outcome with a behavioural model that is compared on every clock: the model commits only on a full eighth bit. Acknowledge sampling in the ninth SCL high phase shows whether the pull-down came at the right point relative to the commit.

// File: rtl/i2c_wr_pkg.sv
package i2c_wr_pkg;
  localparam int BYTE_W   = 8;
  localparam int IDX_W    = 3;
  localparam int PAY_W    = 5;
  localparam int NUM_REGS = 5;
  localparam int CNT_W    = $clog2(BYTE_W) + 1;
  localparam logic [5:0] DEV_ADDR_HI = 6'b111110;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_GAP, ST_ADDR_ACK,
    ST_DATA, ST_DATA_GAP, ST_DATA_ACK, ST_SKIP
  } bus_state_t;

  function automatic logic [PAY_W-1:0] keep_mask(input int idx);
    case (idx)
      0:       keep_mask = 5'b11100;
      1:       keep_mask = 5'b11110;
      default: keep_mask = '1;
    endcase
  endfunction
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES:0] scl_p;
  logic [STAGES:0] sda_p;
  logic scl_now, scl_old, sda_now, sda_old;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_p <= '1;
      sda_p <= '1;
    end else begin
      scl_p <= {scl_p[STAGES-1:0], scl_i};
      sda_p <= {sda_p[STAGES-1:0], sda_i};
    end
  end

  assign scl_now   = scl_p[STAGES-1];
  assign scl_old   = scl_p[STAGES];
  assign sda_now   = sda_p[STAGES-1];
  assign sda_old   = sda_p[STAGES];
  assign sda_s     = sda_now;
  assign scl_rise  = scl_now & ~scl_old;
  assign scl_fall  = ~scl_now & scl_old;
  assign start_det = scl_now & scl_old & sda_old & ~sda_now;
  assign stop_det  = scl_now & scl_old & ~sda_old & sda_now;
endmodule

// File: rtl/i2c_wr_fsm.sv
module i2c_wr_fsm
  import i2c_wr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [6:0]        dev_addr,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  output logic              sda_oe,
  output logic              wr_en,
  output logic [BYTE_W-1:0] wr_byte
);
  bus_state_t        state;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] shreg;
  logic [BYTE_W-1:0] next_byte;
  logic              last_bit;

  assign next_byte = {shreg[BYTE_W-2:0], sda_s};
  assign last_bit  = (bit_cnt == CNT_W'(BYTE_W - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      bit_cnt <= '0;
      shreg   <= '0;
      sda_oe  <= 1'b0;
      wr_en   <= 1'b0;
      wr_byte <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_det) begin
        state   <= ST_ADDR;
        bit_cnt <= '0;
        sda_oe  <= 1'b0;
      end else if (stop_det) begin
        state   <= ST_IDLE;
        bit_cnt <= '0;
        sda_oe  <= 1'b0;
      end else begin
        case (state)
          ST_ADDR: if (scl_rise) begin
            shreg   <= next_byte;
            bit_cnt <= bit_cnt + 1'b1;
            if (last_bit)
              state <= (next_byte == {dev_addr, 1'b0}) ? ST_ADDR_GAP : ST_SKIP;
          end
          ST_ADDR_GAP: if (scl_fall) begin
            sda_oe <= 1'b1;
            state  <= ST_ADDR_ACK;
          end
          ST_ADDR_ACK: if (scl_fall) begin
            sda_oe  <= 1'b0;
            bit_cnt <= '0;
            state   <= ST_DATA;
          end
          ST_DATA: if (scl_rise) begin
            shreg   <= next_byte;
            bit_cnt <= bit_cnt + 1'b1;
            if (last_bit) begin
              wr_en   <= 1'b1;
              wr_byte <= next_byte;
              state   <= ST_DATA_GAP;
            end
          end
          ST_DATA_GAP: if (scl_fall) begin
            sda_oe <= 1'b1;
            state  <= ST_DATA_ACK;
          end
          ST_DATA_ACK: if (scl_fall) begin
            sda_oe <= 1'b0;
            state  <= ST_SKIP;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank
  import i2c_wr_pkg::*;
(
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               wr_en,
  input  logic [BYTE_W-1:0]                  wr_byte,
  output logic [NUM_REGS-1:0][PAY_W-1:0]     regs_q
);
  logic [IDX_W-1:0] wr_idx;
  logic [PAY_W-1:0] wr_val;

  assign wr_idx = wr_byte[BYTE_W-1 -: IDX_W];
  assign wr_val = wr_byte[PAY_W-1:0];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic [PAY_W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst)
        q <= '0;
      else if (wr_en && (wr_idx == IDX_W'(g)))
        q <= wr_val & keep_mask(g);
    end
    assign regs_q[g] = q;
  end
endmodule

// File: rtl/i2c_wr_regs.sv
module i2c_wr_regs
  import i2c_wr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             addr_sel,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe,
  output logic [PAY_W-1:0] mode_q,
  output logic [PAY_W-1:0] diag_q,
  output logic [PAY_W-1:0] fmask_q,
  output logic [PAY_W-1:0] vol1_q,
  output logic [PAY_W-1:0] vol2_q
);
  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic wr_en;
  logic [BYTE_W-1:0] wr_byte;
  logic [NUM_REGS-1:0][PAY_W-1:0] regs_q;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_wr_fsm u_fsm (
    .clk(clk), .rst(rst), .dev_addr({DEV_ADDR_HI, addr_sel}),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det),
    .sda_oe(sda_oe), .wr_en(wr_en), .wr_byte(wr_byte)
  );

  i2c_reg_bank u_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_byte(wr_byte), .regs_q(regs_q)
  );

  assign mode_q  = regs_q[0];
  assign diag_q  = regs_q[1];
  assign fmask_q = regs_q[2];
  assign vol1_q  = regs_q[3];
  assign vol2_q  = regs_q[4];
endmodule

// File: rtl/i2c_wr_regs_chk.sv
module i2c_wr_regs_chk (
  input logic       clk,
  input logic       rst,
  input logic       scl_i,
  input logic       sda_oe,
  input logic [4:0] mode_q,
  input logic [4:0] diag_q,
  input logic [4:0] fmask_q,
  input logic [4:0] vol1_q,
  input logic [4:0] vol2_q
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> ({mode_q, diag_q, fmask_q, vol1_q, vol2_q} == '0 && !sda_oe));

  assert_ack_rise_scl_low_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !scl_i);

  assert_ack_fall_scl_low_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(sda_oe) |-> !scl_i);

  assert_reserved_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (mode_q[1:0] == 2'b00) && !diag_q[0]);

  assert_single_update_R10: assert property (@(posedge clk) disable iff (rst)
    $countones({!$stable(mode_q), !$stable(diag_q), !$stable(fmask_q),
                !$stable(vol1_q), !$stable(vol2_q)}) <= 1);

  assert_no_write_during_ack_R5: assert property (@(posedge clk) disable iff (rst)
    sda_oe |-> $stable({mode_q, diag_q, fmask_q, vol1_q, vol2_q}));
endmodule

bind i2c_wr_regs i2c_wr_regs_chk u_chk (
  .clk(clk), .rst(rst), .scl_i(scl_i), .sda_oe(sda_oe),
  .mode_q(mode_q), .diag_q(diag_q), .fmask_q(fmask_q),
  .vol1_q(vol1_q), .vol2_q(vol2_q)
);

// File: tb/tb_i2c_wr_regs.sv
module tb_i2c_wr_regs;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sel = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic [4:0] mode_q, diag_q, fmask_q, vol1_q, vol2_q;
  wire sda_line = sda_m & ~sda_oe;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  int last_commit = -100;
  bit done = 1'b0;
  logic [4:0] exp_r [5];

  always #4 clk = ~clk;

  i2c_wr_regs dut (
    .clk(clk), .rst(rst), .addr_sel(sel), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe(sda_oe), .mode_q(mode_q), .diag_q(diag_q), .fmask_q(fmask_q),
    .vol1_q(vol1_q), .vol2_q(vol2_q)
  );

  function automatic logic [24:0] dut_regs();
    return {mode_q, diag_q, fmask_q, vol1_q, vol2_q};
  endfunction
  function automatic logic [24:0] exp_regs();
    return {exp_r[0], exp_r[1], exp_r[2], exp_r[3], exp_r[4]};
  endfunction

  // per-clock comparison against the behavioural model (R4)
  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (!rst && !done && (cyc - last_commit > 8)) begin
      n_chk++;
      if (dut_regs() !== exp_regs()) begin
        n_err++;
        $display("FAIL R4 per-cycle regs actual=%h expected=%h", dut_regs(), exp_regs());
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_start();
    wait_clk(8); sda_m = 1'b1;
    wait_clk(8); scl_m = 1'b1;
    wait_clk(8); sda_m = 1'b0;
    wait_clk(8); scl_m = 1'b0;
  endtask

  task automatic send_stop();
    wait_clk(8); sda_m = 1'b0;
    wait_clk(8); scl_m = 1'b1;
    wait_clk(16); sda_m = 1'b1;
    wait_clk(16);
  endtask

  task automatic model_commit(input logic [7:0] d);
    int idx;
    idx = int'(d[7:5]);
    last_commit = cyc;
    if (idx == 0) exp_r[0] = d[4:0] & 5'b11100;
    else if (idx == 1) exp_r[1] = d[4:0] & 5'b11110;
    else if (idx < 5) exp_r[idx] = d[4:0];
  endtask

  // sends the top nbits of b, MSB first; commits to the model on the 8th bit
  task automatic send_bits(input logic [7:0] b, input int nbits, input bit commit);
    for (int i = 7; i > 7 - nbits; i--) begin
      wait_clk(8); sda_m = b[i];
      wait_clk(8); scl_m = 1'b1;
      if (i == 0 && commit) model_commit(b);
      wait_clk(16); scl_m = 1'b0;
    end
  endtask

  task automatic recv_ack(input bit expect_ack, input string req);
    wait_clk(8); sda_m = 1'b1;
    wait_clk(8); scl_m = 1'b1;
    wait_clk(8);
    chk((!sda_line) == expect_ack, req, int'(!sda_line), int'(expect_ack));
    wait_clk(8); scl_m = 1'b0;
  endtask

  task automatic do_write(input logic [6:0] a7, input bit rw, input logic [7:0] d);
    bit hit;
    hit = (a7 == {6'b111110, sel}) && !rw;
    send_start();
    send_bits({a7, rw}, 8, 1'b0);
    recv_ack(hit, hit ? "R2 address ack" : "R3 address nack");
    send_bits(d, 8, hit);
    recv_ack(hit, hit ? "R5 data ack" : "R3 data nack");
    send_stop();
  endtask

  task automatic check_regs(input string req);
    chk(dut_regs() === exp_regs(), req, int'(dut_regs()), int'(exp_regs()));
  endtask

  initial begin
    for (int i = 0; i < 5; i++) exp_r[i] = 5'd0;
    wait_clk(5);
    chk(dut_regs() == 25'd0, "R1 regs after reset", int'(dut_regs()), 0);
    chk(sda_oe == 1'b0, "R1 sda_oe after reset", int'(sda_oe), 0);
    rst = 1'b0;
    wait_clk(10);

    do_write(7'b1111100, 1'b0, 8'h1F);  check_regs("R6 mode reserved bits");
    chk(mode_q == 5'b11100, "R6 mode value", int'(mode_q), 'h1C);
    do_write(7'b1111100, 1'b0, 8'h3F);  check_regs("R6 diag reserved bit");
    chk(diag_q == 5'b11110, "R6 diag value", int'(diag_q), 'h1E);
    do_write(7'b1111100, 1'b0, 8'h55);  check_regs("R4 fault mask write");
    do_write(7'b1111100, 1'b0, 8'h6A);  check_regs("R4 volume 1 write");
    do_write(7'b1111100, 1'b0, 8'h93);  check_regs("R4 volume 2 write");
    chk(vol2_q == 5'h13, "R4 volume 2 value", int'(vol2_q), 'h13);
    do_write(7'b1111100, 1'b0, 8'hBF);  check_regs("R7 index 101 ignored");
    do_write(7'b1111100, 1'b0, 8'hFF);  check_regs("R7 index 111 ignored");
    do_write(7'b1111101, 1'b0, 8'h61);  check_regs("R3 wrong address ignored");
    do_write(7'b1111100, 1'b1, 8'h61);  check_regs("R3 read request ignored");

    sel = 1'b1; wait_clk(10);
    do_write(7'b1111101, 1'b0, 8'h7F);  check_regs("R2 address select one");
    chk(vol1_q == 5'h1F, "R2 volume 1 value", int'(vol1_q), 'h1F);
    do_write(7'b1111100, 1'b0, 8'h00);  check_regs("R3 old address now rejected");

    // STOP in the middle of the data byte
    send_start(); send_bits(8'b11111010, 8, 1'b0); recv_ack(1'b1, "R2 address ack");
    send_bits(8'h8A, 4, 1'b0); send_stop();
    check_regs("R8 stop mid byte no write");

    // START in the middle of the data byte, then a full transfer
    send_start(); send_bits(8'b11111010, 8, 1'b0); recv_ack(1'b1, "R2 address ack");
    send_bits(8'h0C, 5, 1'b0);
    send_start(); send_bits(8'b11111010, 8, 1'b0); recv_ack(1'b1, "R8 restart address ack");
    send_bits(8'h48, 8, 1'b1); recv_ack(1'b1, "R5 data ack after restart");
    send_stop();
    check_regs("R8 restart then write");

    // START in the middle of the address byte
    send_start(); send_bits(8'b11111010, 3, 1'b0);
    send_start(); send_bits(8'b11111010, 8, 1'b0); recv_ack(1'b1, "R8 restart in address");
    send_bits(8'h24, 8, 1'b1); recv_ack(1'b1, "R5 data ack");
    send_stop();
    check_regs("R8 address restart write");

    // second data byte in one transfer
    send_start(); send_bits(8'b11111010, 8, 1'b0); recv_ack(1'b1, "R2 address ack");
    send_bits(8'h9E, 8, 1'b1); recv_ack(1'b1, "R5 data ack");
    send_bits(8'h81, 8, 1'b0); recv_ack(1'b0, "R9 extra byte nack");
    send_stop();
    check_regs("R9 extra byte no write");
    chk(vol2_q == 5'h1E, "R9 volume 2 kept", int'(vol2_q), 'h1E);

    wait_clk(20);
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule